// File: doc/BRIEF.md
# FM Synthesizer Register Write Port

This block is the host side of a six-channel, two-operator FM synthesizer. The host sees two ports that share one data bus. A write to the even port, with `port_sel` low, loads the register address. A write to the odd port, with `port_sel` high, stores the data byte at the loaded address. The address stays loaded, so several data writes in a row all go to the same register.

The decoded contents go straight to the tone engine as parallel outputs:

- the shared custom-instrument operator words, one for the modulator and one for the carrier;
- the 9-bit frequency number of each channel;
- the octave block;
- the key and sustain flags;
- the instrument selector;
- the carrier attenuation derived from the volume nibble.

Key handling is edge-aware. A register write that raises a channel's key bit sends a one-cycle restart strobe to both operators of that channel. A write that clears a key bit that was set sends a one-cycle release strobe, and only to the carrier.

Top module: `fmsynth_regwr`

## Requirements
- R1: When `wr_en` is high and `port_sel` is 0, the low 6 bits of `wr_data` are loaded as the register address, and any higher address bits are dropped. When `wr_en` is high and `port_sel` is 1, `wr_data` is written to the loaded address. The loaded address remains valid for any number of later data writes.
- R2: A data write to an address outside the mapped set has no effect on any output. The unmapped addresses are 0x08–0x0F, 0x16–0x1F, 0x26–0x2F and 0x36–0x3F.
- R3: Addresses 0x00–0x07 hold custom bytes c0..c7. `mod_op_o` = {c0, c2, c3[3], c3[2:0], c4, c6}, where c0 carries the AM, vibrato, sustained-envelope and key-rate flags followed by the multiplier, c2 is the scaling and level, c3[3] is the waveform and c3[2:0] is the feedback. `car_op_o` = {c1, c3[7:6], 6'b0, c3[4], 3'b0, c5, c7}. Bytes c4..c7 hold attack/decay and sustain/release nibbles.
- R4: Address 0x10+n holds the low 8 bits of channel n's frequency number. Bit 0 of address 0x20+n is bit 8 of that number. `fnum_o[9n+8:9n]` = {bit 8, low byte}.
- R5: In address 0x20+n, bits 3:1 drive `block_o` of channel n, bit 4 drives `key_o[n]` and bit 5 drives `sus_o[n]`.
- R6: In address 0x30+n, the upper nibble drives `inst_o` of channel n, where 0 selects the custom instrument. The lower nibble v drives `car_level_o` of channel n as the 6-bit value v<<2.
- R7: A write to 0x20+n with bit 4 set, while `key_o[n]` was 0, raises both `mod_kon_o[n]` and `car_kon_o[n]` in the cycle after the write. If `key_o[n]` was already 1, no restart strobe is produced.
- R8: A write to 0x20+n with bit 4 clear, while `key_o[n]` was 1, raises only `car_koff_o[n]`. If the key was already clear, no strobe is produced. The modulator never receives a release strobe.
- R9: Every strobe is high for exactly one cycle. All strobes are low in any cycle that does not directly follow a data write.
- R10: Reset clears the loaded address to 0x00, clears every register to zero and holds all strobes low. A data write made directly after reset, with no address write, lands in custom byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write enable |
| port_sel | input | 1 | 0: address port, 1: data port |
| wr_data | input | DATA_W | Host write byte |
| mod_op_o | output | 36 | Modulator operator word from the custom instrument |
| car_op_o | output | 36 | Carrier operator word from the custom instrument |
| fnum_o | output | NUM_CH*9 | Frequency number per channel |
| block_o | output | NUM_CH*3 | Octave block per channel |
| key_o | output | NUM_CH | Key flag per channel |
| sus_o | output | NUM_CH | Sustain flag per channel |
| inst_o | output | NUM_CH*4 | Instrument selector per channel |
| car_level_o | output | NUM_CH*6 | Carrier attenuation (volume<<2) per channel |
| mod_kon_o | output | NUM_CH | Modulator restart strobe |
| car_kon_o | output | NUM_CH | Carrier restart strobe |
| car_koff_o | output | NUM_CH | Carrier release strobe |

## Verification
Every stored field reaches a port in the cycle after the write that set it. A wrongly decoded or corrupted register therefore shows up on the decoded outputs at once and stays visible until that register is written again.

Two faults are less direct and only appear when the next write exercises them:

- A wrong key history shows up only at the next write to that channel's key register, as a missing or extra restart or release strobe.
- A wrongly loaded address shows up at the next data write, which either changes the wrong field or changes nothing.

Strobe pulse length and strobe pairing are checked on every cycle.

// File: rtl/fmreg_pkg.sv
package fmreg_pkg;

   // address group carried in address bits [5:4]
   typedef enum logic [1:0] {
      GRP_PATCH = 2'd0,
      GRP_FLO   = 2'd1,
      GRP_FHI   = 2'd2,
      GRP_INSV  = 2'd3
   } reg_grp_e;

   localparam int unsigned MAP_ADDR_W = 6;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned FNUM_W     = 9;
   localparam int unsigned BLOCK_W    = 3;
   localparam int unsigned INST_W     = 4;
   localparam int unsigned LEVEL_W    = 6;
   localparam int unsigned VOL_W      = 4;

   // bit positions inside the high-frequency register
   localparam int unsigned HI_FN8  = 0;
   localparam int unsigned HI_BLK0 = 1;
   localparam int unsigned HI_KEY  = 4;
   localparam int unsigned HI_SUS  = 5;
   localparam int unsigned HI_KEEP = 6;

   typedef struct packed {
      logic       amod;
      logic       vib;
      logic       hold;
      logic       krate;
      logic [3:0] mult;
      logic [1:0] ksl;
      logic [5:0] tl;
      logic       wave;
      logic [2:0] fb;
      logic [3:0] ar;
      logic [3:0] dr;
      logic [3:0] sl;
      logic [3:0] rr;
   } op_word_t;

   localparam int unsigned OP_WORD_W = $bits(op_word_t);

endpackage

// File: rtl/fmreg_hostport.sv
module fmreg_hostport #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              port_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata
);

   logic [ADDR_W-1:0] addr_q;
   logic              addr_we;

   assign addr_we = wr_en & ~port_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_we) begin
         addr_q <= wr_data[ADDR_W-1:0];
      end
   end

   assign reg_we    = wr_en & port_sel;
   assign reg_addr  = addr_q;
   assign reg_wdata = wr_data[7:0];

endmodule

// File: rtl/fmreg_addrdec.sv
module fmreg_addrdec
   import fmreg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned NUM_CH    = 6,
   parameter int unsigned NUM_PATCH = 8
) (
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   output logic [NUM_PATCH-1:0] patch_we,
   output logic [NUM_CH-1:0]    flo_we,
   output logic [NUM_CH-1:0]    fhi_we,
   output logic [NUM_CH-1:0]    insv_we
);

   logic       upper_clear;
   reg_grp_e   grp;
   logic [3:0] idx;

   generate
      if (ADDR_W > MAP_ADDR_W) begin : g_wide
         assign upper_clear = ~|reg_addr[ADDR_W-1:MAP_ADDR_W];
      end else begin : g_exact
         assign upper_clear = 1'b1;
      end
   endgenerate

   assign grp = reg_grp_e'(reg_addr[5:4]);
   assign idx = reg_addr[3:0];

   generate
      for (genvar p = 0; p < NUM_PATCH; p++) begin : g_patch
         assign patch_we[p] = reg_we & upper_clear & (grp == GRP_PATCH) &
                              (idx == 4'(p));
      end
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         logic hit;
         assign hit        = reg_we & upper_clear & (idx == 4'(c));
         assign flo_we[c]  = hit & (grp == GRP_FLO);
         assign fhi_we[c]  = hit & (grp == GRP_FHI);
         assign insv_we[c] = hit & (grp == GRP_INSV);
      end
   endgenerate

endmodule

// File: rtl/fmreg_patch.sv
module fmreg_patch
   import fmreg_pkg::*;
#(
   parameter int unsigned NUM_PATCH = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PATCH-1:0] we,
   input  logic [7:0]           wdata,
   output logic [OP_WORD_W-1:0] mod_op_o,
   output logic [OP_WORD_W-1:0] car_op_o
);

   logic [7:0] byte_q [NUM_PATCH];
   op_word_t   mod_w;
   op_word_t   car_w;

   generate
      for (genvar b = 0; b < NUM_PATCH; b++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q[b] <= '0;
            end else if (we[b]) begin
               byte_q[b] <= wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      mod_w       = '0;
      mod_w.amod  = byte_q[0][7];
      mod_w.vib   = byte_q[0][6];
      mod_w.hold  = byte_q[0][5];
      mod_w.krate = byte_q[0][4];
      mod_w.mult  = byte_q[0][3:0];
      mod_w.ksl   = byte_q[2][7:6];
      mod_w.tl    = byte_q[2][5:0];
      mod_w.wave  = byte_q[3][3];
      mod_w.fb    = byte_q[3][2:0];
      mod_w.ar    = byte_q[4][7:4];
      mod_w.dr    = byte_q[4][3:0];
      mod_w.sl    = byte_q[6][7:4];
      mod_w.rr    = byte_q[6][3:0];

      car_w       = '0;
      car_w.amod  = byte_q[1][7];
      car_w.vib   = byte_q[1][6];
      car_w.hold  = byte_q[1][5];
      car_w.krate = byte_q[1][4];
      car_w.mult  = byte_q[1][3:0];
      car_w.ksl   = byte_q[3][7:6];
      car_w.wave  = byte_q[3][4];
      car_w.ar    = byte_q[5][7:4];
      car_w.dr    = byte_q[5][3:0];
      car_w.sl    = byte_q[7][7:4];
      car_w.rr    = byte_q[7][3:0];
   end

   assign mod_op_o = mod_w;
   assign car_op_o = car_w;

endmodule

// File: rtl/fmreg_chan.sv
module fmreg_chan
   import fmreg_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_lo,
   input  logic               we_hi,
   input  logic               we_iv,
   input  logic [7:0]         wdata,
   output logic [FNUM_W-1:0]  fnum_o,
   output logic [BLOCK_W-1:0] block_o,
   output logic               key_o,
   output logic               sus_o,
   output logic [INST_W-1:0]  inst_o,
   output logic [LEVEL_W-1:0] level_o,
   output logic               mod_kon_o,
   output logic               car_kon_o,
   output logic               car_koff_o
);

   logic [7:0]         lo_q;
   logic [HI_KEEP-1:0] hi_q;
   logic [7:0]         iv_q;
   logic               mkon_q;
   logic               ckon_q;
   logic               ckoff_q;
   logic               key_new;
   logic               rise;
   logic               fall;

   assign key_new = wdata[HI_KEY];
   assign rise    = we_hi &  key_new & ~hi_q[HI_KEY];
   assign fall    = we_hi & ~key_new &  hi_q[HI_KEY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
         iv_q <= '0;
      end else begin
         if (we_lo) lo_q <= wdata;
         if (we_hi) hi_q <= wdata[HI_KEEP-1:0];
         if (we_iv) iv_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mkon_q  <= 1'b0;
         ckon_q  <= 1'b0;
         ckoff_q <= 1'b0;
      end else begin
         mkon_q  <= rise;
         ckon_q  <= rise;
         ckoff_q <= fall;
      end
   end

   assign fnum_o     = {hi_q[HI_FN8], lo_q};
   assign block_o    = hi_q[HI_BLK0 +: BLOCK_W];
   assign key_o      = hi_q[HI_KEY];
   assign sus_o      = hi_q[HI_SUS];
   assign inst_o     = iv_q[7:4];
   assign level_o    = {iv_q[VOL_W-1:0], 2'b00};
   assign mod_kon_o  = mkon_q;
   assign car_kon_o  = ckon_q;
   assign car_koff_o = ckoff_q;

endmodule

// File: rtl/fmsynth_regwr.sv
module fmsynth_regwr
   import fmreg_pkg::*;
#(
   parameter int unsigned NUM_CH    = 6,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_PATCH = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      port_sel,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [35:0]               mod_op_o,
   output logic [35:0]               car_op_o,
   output logic [NUM_CH*9-1:0]       fnum_o,
   output logic [NUM_CH*3-1:0]       block_o,
   output logic [NUM_CH-1:0]         key_o,
   output logic [NUM_CH-1:0]         sus_o,
   output logic [NUM_CH*4-1:0]       inst_o,
   output logic [NUM_CH*6-1:0]       car_level_o,
   output logic [NUM_CH-1:0]         mod_kon_o,
   output logic [NUM_CH-1:0]         car_kon_o,
   output logic [NUM_CH-1:0]         car_koff_o
);

   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
         $error("NUM_CH must be 1..16");
      end
      if (ADDR_W < MAP_ADDR_W || ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must lie between 6 and DATA_W");
      end
      if (DATA_W != BYTE_W) begin : g_bad_data
         $error("DATA_W must be 8");
      end
      if (NUM_PATCH != 8) begin : g_bad_patch
         $error("NUM_PATCH must be 8");
      end
      if (OP_WORD_W != 36) begin : g_bad_word
         $error("operator word must be 36 bits");
      end
   endgenerate

   logic                 reg_we;
   logic [ADDR_W-1:0]    reg_addr;
   logic [7:0]           reg_wdata;
   logic [NUM_PATCH-1:0] patch_we;
   logic [NUM_CH-1:0]    flo_we;
   logic [NUM_CH-1:0]    fhi_we;
   logic [NUM_CH-1:0]    insv_we;

   fmreg_hostport #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .port_sel  (port_sel),
      .wr_data   (wr_data),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata)
   );

   fmreg_addrdec #(
      .ADDR_W    (ADDR_W),
      .NUM_CH    (NUM_CH),
      .NUM_PATCH (NUM_PATCH)
   ) u_dec (
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .patch_we (patch_we),
      .flo_we   (flo_we),
      .fhi_we   (fhi_we),
      .insv_we  (insv_we)
   );

   fmreg_patch #(
      .NUM_PATCH (NUM_PATCH)
   ) u_patch (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (patch_we),
      .wdata    (reg_wdata),
      .mod_op_o (mod_op_o),
      .car_op_o (car_op_o)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         fmreg_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_lo      (flo_we[c]),
            .we_hi      (fhi_we[c]),
            .we_iv      (insv_we[c]),
            .wdata      (reg_wdata),
            .fnum_o     (fnum_o[c*FNUM_W +: FNUM_W]),
            .block_o    (block_o[c*BLOCK_W +: BLOCK_W]),
            .key_o      (key_o[c]),
            .sus_o      (sus_o[c]),
            .inst_o     (inst_o[c*INST_W +: INST_W]),
            .level_o    (car_level_o[c*LEVEL_W +: LEVEL_W]),
            .mod_kon_o  (mod_kon_o[c]),
            .car_kon_o  (car_kon_o[c]),
            .car_koff_o (car_koff_o[c])
         );
      end
   endgenerate

endmodule

// File: rtl/fmsynth_regwr_chk.sv
module fmsynth_regwr_chk #(
   parameter int unsigned NUM_CH = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                port_sel,
   input logic [NUM_CH*9-1:0] fnum_o,
   input logic [NUM_CH-1:0]   key_o,
   input logic [NUM_CH-1:0]   mod_kon_o,
   input logic [NUM_CH-1:0]   car_kon_o,
   input logic [NUM_CH-1:0]   car_koff_o
);

   // R4: frequency numbers move only after a data write
   a_r4_fnum_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && port_sel) |-> $stable(fnum_o));

   // R9: no strobe unless the previous cycle carried a data write
   a_r9_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|{mod_kon_o, car_kon_o, car_koff_o}) |-> $past(wr_en && port_sel));

   // R10: registers and strobes leave reset cleared
   a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fnum_o == '0 && key_o == '0 && car_kon_o == '0));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_c
         a_r7_kon_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            car_kon_o[i] |-> (key_o[i] && !$past(key_o[i])));
         a_r7_ops_paired: assert property (@(posedge clk) disable iff (!rst_n)
            mod_kon_o[i] == car_kon_o[i]);
         a_r8_koff_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
            car_koff_o[i] |-> (!key_o[i] && $past(key_o[i])));
         a_r8_key_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
            (key_o[i] != $past(key_o[i])) |-> (car_kon_o[i] || car_koff_o[i]));
         a_r9_kon_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            car_kon_o[i] |=> !car_kon_o[i]);
      end
   endgenerate

endmodule

bind fmsynth_regwr fmsynth_regwr_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .port_sel   (port_sel),
   .fnum_o     (fnum_o),
   .key_o      (key_o),
   .mod_kon_o  (mod_kon_o),
   .car_kon_o  (car_kon_o),
   .car_koff_o (car_koff_o)
);

// File: tb/fmsynth_regwr_tb_top.sv
module fmsynth_regwr_tb_top;

   localparam int NCH = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic             wr_en;
   logic             port_sel;
   logic [7:0]       wr_data;
   logic [35:0]      mod_op_o;
   logic [35:0]      car_op_o;
   logic [NCH*9-1:0] fnum_o;
   logic [NCH*3-1:0] block_o;
   logic [NCH-1:0]   key_o;
   logic [NCH-1:0]   sus_o;
   logic [NCH*4-1:0] inst_o;
   logic [NCH*6-1:0] car_level_o;
   logic [NCH-1:0]   mod_kon_o;
   logic [NCH-1:0]   car_kon_o;
   logic [NCH-1:0]   car_koff_o;

   fmsynth_regwr dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
      .wr_data(wr_data), .mod_op_o(mod_op_o), .car_op_o(car_op_o),
      .fnum_o(fnum_o), .block_o(block_o), .key_o(key_o), .sus_o(sus_o),
      .inst_o(inst_o), .car_level_o(car_level_o), .mod_kon_o(mod_kon_o),
      .car_kon_o(car_kon_o), .car_koff_o(car_koff_o)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0]     m_cust [8];
   logic [7:0]     m_lo   [NCH];
   logic [7:0]     m_hi   [NCH];
   logic [7:0]     m_iv   [NCH];
   logic [5:0]     m_addr;
   logic [NCH-1:0] e_kon;
   logic [NCH-1:0] e_koff;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_cust[i] = '0;
      for (int i = 0; i < NCH; i++) begin
         m_lo[i] = '0; m_hi[i] = '0; m_iv[i] = '0;
      end
      m_addr = '0; e_kon = '0; e_koff = '0;
   endtask

   task automatic model_write(input logic [7:0] d);
      int idx;
      idx = int'(m_addr[3:0]);
      e_kon = '0; e_koff = '0;
      case (m_addr[5:4])
         2'd0: if (idx < 8) m_cust[idx] = d;
         2'd1: if (idx < NCH) m_lo[idx] = d;
         2'd2: if (idx < NCH) begin
            if (d[4] && !m_hi[idx][4]) e_kon[idx] = 1'b1;
            if (!d[4] && m_hi[idx][4]) e_koff[idx] = 1'b1;
            m_hi[idx] = d;
         end
         default: if (idx < NCH) m_iv[idx] = d;
      endcase
   endtask

   function automatic logic [35:0] exp_mod();
      return {m_cust[0], m_cust[2], m_cust[3][3], m_cust[3][2:0], m_cust[4], m_cust[6]};
   endfunction

   function automatic logic [35:0] exp_car();
      return {m_cust[1], m_cust[3][7:6], 6'd0, m_cust[3][4], 3'd0, m_cust[5], m_cust[7]};
   endfunction

   task automatic check_all(input string tag);
      logic [NCH*9-1:0] ef;
      logic [NCH*3-1:0] eb;
      logic [NCH-1:0]   ek, es;
      logic [NCH*4-1:0] ei;
      logic [NCH*6-1:0] el;
      for (int c = 0; c < NCH; c++) begin
         ef[c*9 +: 9] = {m_hi[c][0], m_lo[c]};
         eb[c*3 +: 3] = m_hi[c][3:1];
         ek[c]        = m_hi[c][4];
         es[c]        = m_hi[c][5];
         ei[c*4 +: 4] = m_iv[c][7:4];
         el[c*6 +: 6] = {m_iv[c][3:0], 2'b00};
      end
      chk(mod_op_o == exp_mod(), "R3", {tag, " mod_op"}, 64'(mod_op_o), 64'(exp_mod()));
      chk(car_op_o == exp_car(), "R3", {tag, " car_op"}, 64'(car_op_o), 64'(exp_car()));
      chk(fnum_o == ef, "R4", {tag, " fnum"}, 64'(fnum_o), 64'(ef));
      chk(block_o == eb && key_o == ek && sus_o == es, "R5", {tag, " block/key/sus"},
          64'({block_o, key_o, sus_o}), 64'({eb, ek, es}));
      chk(inst_o == ei && car_level_o == el, "R6", {tag, " inst/level"},
          64'({inst_o, car_level_o}), 64'({ei, el}));
   endtask

   task automatic check_strobes(input string tag);
      chk(mod_kon_o == e_kon && car_kon_o == e_kon, "R7", {tag, " key-on strobes"},
          64'({mod_kon_o, car_kon_o}), 64'({e_kon, e_kon}));
      chk(car_koff_o == e_koff, "R8", {tag, " carrier release strobe"},
          64'(car_koff_o), 64'(e_koff));
   endtask

   task automatic bus_addr(input logic [7:0] a);
      @(negedge clk);
      wr_en = 1'b1; port_sel = 1'b0; wr_data = a;
      @(negedge clk);
      wr_en = 1'b0;
      m_addr = a[5:0];
   endtask

   task automatic bus_data(input logic [7:0] d, input string tag);
      @(negedge clk);
      wr_en = 1'b1; port_sel = 1'b1; wr_data = d;
      model_write(d);
      @(negedge clk);
      wr_en = 1'b0;
      check_all(tag);
      check_strobes(tag);
      @(negedge clk);
      e_kon = '0; e_koff = '0;
      chk(mod_kon_o == '0 && car_kon_o == '0 && car_koff_o == '0, "R9",
          {tag, " strobes one cycle"}, 64'({mod_kon_o, car_kon_o, car_koff_o}), 64'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] a, d;
      void'($urandom(32'h1f2e3d4c));
      rst_n = 1'b0; wr_en = 1'b0; port_sel = 1'b0; wr_data = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10 reset state");
      check_strobes("R10 reset state");

      // R10: data write before any address write lands in byte 0
      bus_data(8'hA5, "R10 default address");
      // R1: address masked to 6 bits, repeated data writes reuse it
      bus_addr(8'hD3);
      bus_data(8'h7E, "R1 masked address");
      bus_data(8'h81, "R1 latched address reuse");
      // R2: unmapped addresses change nothing
      bus_addr(8'h08); bus_data(8'hFF, "R2 unmapped 0x08");
      bus_addr(8'h16); bus_data(8'hFF, "R2 unmapped 0x16");
      bus_addr(8'h2F); bus_data(8'hFF, "R2 unmapped 0x2F");
      bus_addr(8'h3F); bus_data(8'hFF, "R2 unmapped 0x3F");
      // R7/R8 key edge handling on channel 2
      bus_addr(8'h22);
      bus_data(8'h00, "R8 release while idle");
      bus_data(8'h13, "R7 key rise");
      bus_data(8'h3B, "R7 key held no restart");
      bus_data(8'h21, "R8 key fall");
      bus_data(8'h00, "R8 second release ignored");
      bus_addr(8'h25);
      bus_data(8'h1F, "R7 key rise ch5");
      bus_addr(8'h35);
      bus_data(8'h9F, "R6 inst/volume ch5");
      // R3 full custom patch
      for (int i = 0; i < 8; i++) begin
         bus_addr(8'(i));
         bus_data(8'(8'h5A ^ (i * 8'h37)), "R3 patch byte");
      end

      // constrained random mix
      for (int n = 0; n < 700; n++) begin
         if ($urandom % 3 == 0) begin
            case ($urandom % 5)
               0: a = 8'($urandom % 8);
               1: a = 8'(8'h10 + $urandom % NCH);
               2: a = 8'(8'h20 + $urandom % NCH);
               3: a = 8'(8'h30 + $urandom % NCH);
               default: a = 8'($urandom);
            endcase
            a[7:6] = 2'($urandom);
            bus_addr(a);
         end
         d = 8'($urandom);
         bus_data(d, "R1 random");
      end

      // R10: reset in mid-run clears everything, address back to 0
      do_reset();
      @(negedge clk);
      check_all("R10 mid-run reset");
      bus_data(8'h3C, "R10 address cleared by reset");

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule